// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block runs accesses to a clocked, PSRAM-style external memory. A host hands it one request at a time: a start address, a direction bit and, for a write, one data word. The engine asserts chip select and presents the address for a single cycle, marked by an address-valid strobe. For a read, it then waits a programmed latency and captures a programmed number of consecutive words, one per clock. Each captured word leaves the block as one beat on an output stream that carries a beat index and an end-of-burst flag.

After the last data cycle, chip select stays asserted for a programmed hold time. It is also stretched so that it meets a programmed minimum read cycle. Chip select then stays released for a programmed minimum interval, and no new request is taken before that interval ends. A write is a single beat. The write strobe and the data are driven for a programmed setup time, and the data is then held for a programmed hold time.

The timing fields are plain inputs, and the engine copies them when it accepts a request. The request side is valid/ready. Once the host raises `req_valid`, it must keep the valid signal, the direction, the address and the write data unchanged until a clock edge at which `req_ready` is also high. `req_ready` is high only while the engine is idle and the chip-select interval has elapsed. The read-beat stream has a valid signal but no ready signal, because a synchronous memory cannot be paused in the middle of a burst. The consumer must take every beat in the cycle in which `rd_valid` is high.

Top module: `psbe_top`

## Requirements
- R1: While reset is held, and after it until the first request, `mem_cs_n`, `mem_adv_n` and `mem_we_n` are 1, `mem_dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: A request is taken on a rising edge at which `req_valid` and `req_ready` are both 1. In the next cycle (the address cycle) `mem_cs_n` and `mem_adv_n` are 0 and `mem_addr` equals the request address. `mem_adv_n` is 0 for exactly one cycle per access, and `req_ready` is 0 whenever `mem_cs_n` is 0.
- R3: The 3-bit burst code gives the number of read beats: codes 0 to 6 give 1, 2, 4, 8, 16, 32 and 64 beats, and code 7 gives 1 beat.
- R4: With latency field L, the word on `mem_dq_in` is sampled at the end of cycle 1+L after the address cycle (address cycle = cycle 0). It is delivered on `rd_data`, with `rd_valid` high, one cycle after it is sampled.
- R5: The beats of a burst appear in consecutive cycles with `rd_index` counting 0, 1, ... up to the beat count minus 1. `rd_last` is 1 only on the final beat, and `rd_valid` is 0 outside a burst.
- R6: For a read with hold field H, `mem_cs_n` stays 0 for at least H cycles after the last data cycle.
- R7: For a read, `mem_cs_n` stays 0 for exactly max(1+L+beats+H, C+1) cycles, where C is the read-cycle field.
- R8: After any access, `mem_cs_n` stays 1 and `req_ready` stays 0 for exactly G+1 cycles, where G is the chip-select interval field. `req_ready` then returns to 1.
- R9: A write with setup field S and hold field W drives `mem_we_n` low in cycles 1 to 1+S. It drives `mem_dq_oe` high with `mem_dq_out` equal to the write data in cycles 1 to 1+S+W, and releases `mem_cs_n` after 2+S+W cycles.
- R10: Timing fields are taken at the edge that accepts a request. Changing them while that access is in progress has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Engine can take a request |
| req_write | input | 1 | 1 = single-beat write, 0 = burst read |
| req_addr | input | ADDR_W | Start address |
| req_wdata | input | DATA_W | Write data |
| cfg_burst_code | input | 3 | Burst length code |
| cfg_latency | input | 4 | Address-to-first-data wait, n cycles |
| cfg_rd_cycle | input | 4 | Minimum read chip-select time, n+1 cycles |
| cfg_rd_hold | input | 4 | Chip-select hold after last read data, n cycles |
| cfg_cs_gap | input | 4 | Minimum chip-select high interval, n+1 cycles |
| cfg_wr_setup | input | 4 | Write strobe/data setup, n+1 cycles |
| cfg_wr_hold | input | 4 | Write data hold after strobe, n cycles |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Write data to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DATA_W | Read data from memory |
| rd_valid | output | 1 | Read beat present |
| rd_data | output | DATA_W | Read beat word |
| rd_index | output | 6 | Beat number within the burst |
| rd_last | output | 1 | Final beat of the burst |

## Verification
The memory model in the bench drives each cycle a word that encodes the address and the number of cycles since the address strobe. Because of this, a latency counter that is off by one shows up in the first delivered beat as a wrong word, and a beat counter that is off shows up as a missing or extra beat at the end of the burst. Errors in the hold or read-cycle counters change the measured chip-select low time in the cycle where chip select rises. An interval counter error moves the cycle in which `req_ready` returns. A timing snapshot that tracks the live inputs is exposed by changing the fields right after acceptance. Every such fault is therefore visible at the ports within the access it corrupts.

// File: rtl/psbe_pkg.sv
package psbe_pkg;

  localparam int BEAT_IDX_W = 6;
  localparam int PHASE_W    = BEAT_IDX_W + 1;
  localparam int TFIELD_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LAT,
    ST_DATA,
    ST_RHOLD,
    ST_WSET,
    ST_WHOLD,
    ST_GAP
  } psbe_state_e;

  typedef struct packed {
    logic [2:0]          burst_code;
    logic [TFIELD_W-1:0] latency;
    logic [TFIELD_W-1:0] rd_cycle;
    logic [TFIELD_W-1:0] rd_hold;
    logic [TFIELD_W-1:0] cs_gap;
    logic [TFIELD_W-1:0] wr_setup;
    logic [TFIELD_W-1:0] wr_hold;
  } psbe_timing_t;

  // Beat count minus one for a burst code; the reserved code falls back to one beat.
  function automatic logic [PHASE_W-1:0] beats_minus_one(input logic [2:0] code);
    logic [PHASE_W-1:0] r;
    if (code == 3'd7) r = '0;
    else              r = (PHASE_W'(1) << code) - PHASE_W'(1);
    return r;
  endfunction

endpackage

// File: rtl/psbe_countdown.sv
module psbe_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // Once empty, the counter stays empty until reloaded.
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero && !load |=> zero);

endmodule

// File: rtl/psbe_beat_pipe.sv
module psbe_beat_pipe #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last_in,
  input  logic [DATA_W-1:0] din,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_index,
  output logic              rd_last
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_index <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= take;
      rd_last  <= take && last_in;
      if (take) begin
        rd_data  <= din;
        rd_index <= (rd_valid && !rd_last) ? rd_index + IDX_W'(1) : '0;
      end
    end
  end

  // R5
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R5
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_last |=> rd_valid && (rd_index == $past(rd_index) + IDX_W'(1)));

endmodule

// File: rtl/psbe_top.sv
module psbe_top
  import psbe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [2:0]            cfg_burst_code,
  input  logic [3:0]            cfg_latency,
  input  logic [3:0]            cfg_rd_cycle,
  input  logic [3:0]            cfg_rd_hold,
  input  logic [3:0]            cfg_cs_gap,
  input  logic [3:0]            cfg_wr_setup,
  input  logic [3:0]            cfg_wr_hold,
  output logic                  mem_cs_n,
  output logic                  mem_adv_n,
  output logic                  mem_we_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [BEAT_IDX_W-1:0] rd_index,
  output logic                  rd_last
);

  psbe_state_e        state, nxt;
  psbe_timing_t       acc;
  psbe_timing_t       cfg_now;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               accept;
  logic               ph_load, ph_zero;
  logic [PHASE_W-1:0] ph_val;
  logic               cyc_zero;

  assign cfg_now = '{burst_code: cfg_burst_code, latency: cfg_latency,
                     rd_cycle: cfg_rd_cycle, rd_hold: cfg_rd_hold,
                     cs_gap: cfg_cs_gap, wr_setup: cfg_wr_setup,
                     wr_hold: cfg_wr_hold};

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  // Request capture and timing snapshot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      acc     <= cfg_now;
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // Sequencer: each phase loads the shared phase counter on entry
  always_comb begin
    nxt     = state;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) nxt = ST_ADDR;
      end
      ST_ADDR: begin
        ph_load = 1'b1;
        if (wr_q) begin
          nxt    = ST_WSET;
          ph_val = PHASE_W'(acc.wr_setup);
        end else if (acc.latency != '0) begin
          nxt    = ST_LAT;
          ph_val = PHASE_W'(acc.latency - 4'd1);
        end else begin
          nxt    = ST_DATA;
          ph_val = beats_minus_one(acc.burst_code);
        end
      end
      ST_LAT: begin
        if (ph_zero) begin
          nxt     = ST_DATA;
          ph_load = 1'b1;
          ph_val  = beats_minus_one(acc.burst_code);
        end
      end
      ST_DATA: begin
        if (ph_zero) begin
          ph_load = 1'b1;
          if (acc.rd_hold == '0 && cyc_zero) begin
            nxt    = ST_GAP;
            ph_val = PHASE_W'(acc.cs_gap);
          end else begin
            nxt    = ST_RHOLD;
            ph_val = (acc.rd_hold == '0) ? '0 : PHASE_W'(acc.rd_hold - 4'd1);
          end
        end
      end
      ST_RHOLD: begin
        if (ph_zero && cyc_zero) begin
          nxt     = ST_GAP;
          ph_load = 1'b1;
          ph_val  = PHASE_W'(acc.cs_gap);
        end
      end
      ST_WSET: begin
        if (ph_zero) begin
          ph_load = 1'b1;
          if (acc.wr_hold == '0) begin
            nxt    = ST_GAP;
            ph_val = PHASE_W'(acc.cs_gap);
          end else begin
            nxt    = ST_WHOLD;
            ph_val = PHASE_W'(acc.wr_hold - 4'd1);
          end
        end
      end
      ST_WHOLD: begin
        if (ph_zero) begin
          nxt     = ST_GAP;
          ph_load = 1'b1;
          ph_val  = PHASE_W'(acc.cs_gap);
        end
      end
      ST_GAP: begin
        if (ph_zero) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  psbe_countdown #(.W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  // Minimum read chip-select time, counted from the address cycle
  psbe_countdown #(.W(TFIELD_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_rd_cycle), .zero(cyc_zero)
  );

  psbe_beat_pipe #(.DATA_W(DATA_W), .IDX_W(BEAT_IDX_W)) u_beats (
    .clk(clk), .rst_n(rst_n),
    .take(state == ST_DATA), .last_in(ph_zero), .din(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index), .rd_last(rd_last)
  );

  assign mem_cs_n   = (state == ST_IDLE) || (state == ST_GAP);
  assign mem_adv_n  = (state != ST_ADDR);
  assign mem_we_n   = (state != ST_WSET);
  assign mem_dq_oe  = (state == ST_WSET) || (state == ST_WHOLD);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  // R2
  adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  // R9
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

  // R8
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> !req_ready);

  // R7
  read_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) && !wr_q |-> $past(cyc_zero));

endmodule

// File: tb/sim_psbe_top.sv
`timescale 1ns/1ps
module sim_psbe_top;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [2:0]  code;
    logic [3:0]  lat, rcyc, hold, gap, ws, wh;
  } vec_t;

  // wr, addr, wdata, code, lat, rcyc, hold, gap, ws, wh
  localparam vec_t VEC [11] = '{
    '{1'b0, 16'h1000, 16'h0000, 3'd0, 4'd0,  4'd0, 4'd0,  4'd0,  4'd0, 4'd0},
    '{1'b0, 16'h2222, 16'h0000, 3'd1, 4'd3,  4'd5, 4'd1,  4'd1,  4'd0, 4'd0},
    '{1'b0, 16'h3000, 16'h0000, 3'd2, 4'd2,  4'd0, 4'd0,  4'd2,  4'd0, 4'd0},
    '{1'b0, 16'h4440, 16'h0000, 3'd3, 4'd1,  4'd0, 4'd2,  4'd0,  4'd0, 4'd0},
    '{1'b0, 16'h5000, 16'h0000, 3'd0, 4'd0,  4'd9, 4'd0,  4'd3,  4'd0, 4'd0},
    '{1'b0, 16'h6000, 16'h0000, 3'd1, 4'd0,  4'd6, 4'd2,  4'd0,  4'd0, 4'd0},
    '{1'b1, 16'h7000, 16'hBEEF, 3'd0, 4'd0,  4'd0, 4'd0,  4'd0,  4'd0, 4'd0},
    '{1'b1, 16'h7100, 16'h1234, 3'd0, 4'd0,  4'd0, 4'd0,  4'd1,  4'd1, 4'd0},
    '{1'b1, 16'h7200, 16'hA5A5, 3'd0, 4'd0,  4'd0, 4'd0,  4'd2,  4'd3, 4'd2},
    '{1'b0, 16'h8000, 16'h0000, 3'd7, 4'd2,  4'd0, 4'd0,  4'd0,  4'd0, 4'd0},
    '{1'b0, 16'h9000, 16'h0000, 3'd4, 4'd15, 4'd0, 4'd15, 4'd15, 4'd0, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  cfg_burst_code = '0;
  logic [3:0]  cfg_latency = '0, cfg_rd_cycle = '0, cfg_rd_hold = '0;
  logic [3:0]  cfg_cs_gap = '0, cfg_wr_setup = '0, cfg_wr_hold = '0;
  logic        mem_cs_n, mem_adv_n, mem_we_n, mem_dq_oe;
  logic [23:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = '0;
  logic        rd_valid, rd_last;
  logic [15:0] rd_data;
  logic [5:0]  rd_index;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  psbe_top u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_burst_code(cfg_burst_code), .cfg_latency(cfg_latency),
    .cfg_rd_cycle(cfg_rd_cycle), .cfg_rd_hold(cfg_rd_hold),
    .cfg_cs_gap(cfg_cs_gap), .cfg_wr_setup(cfg_wr_setup), .cfg_wr_hold(cfg_wr_hold),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index), .rd_last(rd_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_burst_code = v.code;
    cfg_latency    = v.lat;
    cfg_rd_cycle   = v.rcyc;
    cfg_rd_hold    = v.hold;
    cfg_cs_gap     = v.gap;
    cfg_wr_setup   = v.ws;
    cfg_wr_hold    = v.wh;
  endtask

  // One access, observed at falling edges; t = 0 is the address cycle.
  task automatic run_txn(input vec_t v, input bit scramble, input string tag);
    int beats, exp_cs, cs_low, cs_high, seen, bad_beat, bad_adv, bad_wr, t, k;
    beats = (v.code == 3'd7) ? 1 : (1 << v.code);
    if (v.wr) exp_cs = 2 + v.ws + v.wh;
    else begin
      exp_cs = 1 + v.lat + beats + v.hold;
      if (v.rcyc + 1 > exp_cs) exp_cs = v.rcyc + 1;
    end
    cs_low = 0; cs_high = 0; seen = 0; bad_beat = 0; bad_adv = 0; bad_wr = 0;
    apply_cfg(v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = 24'(v.addr);
    req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_burst_code = ~v.code; cfg_latency = ~v.lat; cfg_rd_cycle = ~v.rcyc;
      cfg_rd_hold = ~v.hold; cfg_cs_gap = ~v.gap; cfg_wr_setup = ~v.ws; cfg_wr_hold = ~v.wh;
    end
    check(mem_addr == 24'(v.addr) && !mem_adv_n && !mem_cs_n,
          {"R2 address cycle ", tag}, int'(mem_addr), int'(v.addr));
    t = 0;
    while (t < 400) begin
      if (t > 0 && !mem_adv_n) bad_adv++;
      if (!mem_cs_n) cs_low++; else cs_high++;
      mem_dq_in = v.addr ^ 16'(t);
      if (!v.wr) begin
        if (t >= 2 + v.lat && t < 2 + v.lat + beats) begin
          k = t - 2 - v.lat;
          seen++;
          if (!rd_valid || rd_data != (v.addr ^ 16'(1 + v.lat + k)) ||
              int'(rd_index) != k || rd_last != (k == beats - 1)) bad_beat++;
        end else if (rd_valid) bad_beat++;
      end else begin
        if (mem_we_n == (t >= 1 && t <= 1 + v.ws)) bad_wr++;
        if (t >= 1 && t <= 1 + v.ws + v.wh) begin
          if (!mem_dq_oe || mem_dq_out != v.wdata) bad_wr++;
        end else if (mem_dq_oe) bad_wr++;
      end
      t++;
      @(negedge clk);
      if (req_ready) break;
    end
    if (v.wr) begin
      check(cs_low == exp_cs, {"R9 write select time ", tag}, cs_low, exp_cs);
      check(bad_wr == 0, {"R9 write strobe/data ", tag}, bad_wr, 0);
    end else begin
      check(cs_low == exp_cs, {"R6 R7 read select time ", tag}, cs_low, exp_cs);
      check(seen == beats && bad_beat == 0, {"R3 R4 R5 beats ", tag}, bad_beat, 0);
    end
    check(bad_adv == 0, {"R2 single strobe ", tag}, bad_adv, 0);
    check(cs_high == v.gap + 1, {"R8 select interval ", tag}, cs_high, v.gap + 1);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_adv_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
          "R1 outputs in reset", 0, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_cs_n && mem_adv_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
          "R1 outputs after reset", 0, 1);

    foreach (VEC[i]) run_txn(VEC[i], 1'b0, $sformatf("vec%0d", i));

    // R3 long bursts: codes 5 and 6
    run_txn('{1'b0, 16'hA000, 16'h0, 3'd5, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0}, 1'b0, "R3 32 beats");
    run_txn('{1'b0, 16'hB000, 16'h0, 3'd6, 4'd4, 4'd0, 4'd3, 4'd0, 4'd0, 4'd0}, 1'b0, "R3 64 beats");
    // R10 timing inputs changed right after acceptance
    run_txn('{1'b0, 16'hC000, 16'h0, 3'd2, 4'd3, 4'd8, 4'd1, 4'd2, 4'd0, 4'd0}, 1'b1, "R10 read");
    run_txn('{1'b1, 16'hD000, 16'h5A5A, 3'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd2, 4'd1}, 1'b1, "R10 write");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule